// File: doc/BRIEF.md
# Trapezoidal Step-Clock Generator

This block drives the step and direction lines of a stepper motor driver through a whole move with no software in the timing path. A free-running counter advances on a tick taken from the system clock through a power-of-two prescaler. A compare register sets when the step line toggles next. After each match the next interval is added to the compare register, so edge timing never depends on when the update is made, and errors cannot build up from one edge to the next.

Each step is made of a low half-period followed by a high half-period. Both halves use the same half-period value from a small ramp table. The table is walked forward while the motor speeds up. The last entry is held while cruising. The table is walked backward to slow down, so every move is symmetric: a trapezoid, or a triangle when the move is too short to reach cruise. If a half-period is longer than the counter can span, it is split into silent segments that do not toggle the line. A signed position counter tracks every step. Software loads the table while the block is idle, then issues one start command with a step count, a direction and a prescaler setting.

Top module: `stepclk_gen`

## Requirements
- R1: After reset the step line is low, the direction line is low, the position is zero and busy is low.
- R2: The prescaler setting p (0 to 2^PSEL_W-1) is latched at start. The counter advances once every 2^p clock cycles, so a half-period of value v lasts exactly v*2^p clock cycles.
- R3: The step line toggles on compare matches. Every step is one rising toggle followed by one falling toggle, and a move of N steps gives exactly N rising edges.
- R4: Step k of an N-step move (k from 1) uses table entry min(k-1, N-k, TBL_DEPTH-1). That value sets the low half before the rising edge of step k and the high half after it.
- R5: A half-period larger than 2^CNT_W-1 counter ticks is made up of silent segments of at most 2^CNT_W-1 ticks, and its total length stays exact.
- R6: The direction is latched at start and held for the whole move. The first rising edge comes at least MIN_LEAD-1 ticks plus one table half-period after start.
- R7: The signed position changes only on a rising step edge: +1 when the latched direction is 1, -1 when it is 0. It accumulates across moves and is not cleared by start.
- R8: Busy goes high on the cycle after an accepted start and goes low on the same edge as the falling toggle that ends the last step. The step line is low whenever busy is low.
- R9: A start while busy is ignored, including its count, direction and prescaler. A start with a step count of zero is ignored.
- R10: The table is written through address, data and write enable, and only while idle. Writes while busy are ignored. An entry of zero acts as a half-period of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a move (one-cycle pulse) |
| steps_i | input | STEP_W | Number of steps in the move |
| dir_i | input | 1 | Direction for the move |
| presc_i | input | PSEL_W | Prescaler exponent p, tick = clk / 2^p |
| tbl_we_i | input | 1 | Ramp table write enable |
| tbl_addr_i | input | $clog2(TBL_DEPTH) | Ramp table write address |
| tbl_data_i | input | TBL_W | Half-period value, in ticks |
| step_o | output | 1 | Step clock to the driver |
| dir_o | output | 1 | Latched direction to the driver |
| pos_o | output | POS_W | Signed step position |
| busy_o | output | 1 | Move in progress |

## Verification
The bound checker watches, on every cycle, the relations between the ports. The step line rests low and changes only during a move. Busy ends only together with a falling step edge. The position moves only on a rising edge, by exactly one in the latched direction. The direction line does not change during a move. The bench alone can show the cycle-exact half-period lengths for each prescaler setting, the forward, hold and reverse order of table entries for long and short moves, the exact splitting of intervals longer than the counter range, and the fact that starts and table writes during a move have no effect.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LEAD = 2'd1,
      PH_LOW  = 2'd2,
      PH_HIGH = 2'd3
   } stepclk_phase_t;

endpackage

// File: rtl/stepclk_timebase.sv
module stepclk_timebase #(
   parameter int CNT_W  = 16,
   parameter int PSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSEL_W-1:0] psel,
   output logic              tick_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam int DIV_W = (1 << PSEL_W) - 1;

   generate
      if (DIV_W == 0) begin : g_nodiv
         assign tick_o = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] mask;
         assign mask   = DIV_W'((1 << psel) - 1);
         assign tick_o = ((div_q & mask) == mask);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else        div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (tick_o) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/stepclk_ramp_mem.sv
module stepclk_ramp_mem #(
   parameter int TBL_W     = 16,
   parameter int TBL_DEPTH = 64,
   localparam int AW       = $clog2(TBL_DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [TBL_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [TBL_W-1:0] rdata
);
   logic [TBL_W-1:0] rows [TBL_DEPTH];

   always_ff @(posedge clk) begin
      if (we) rows[waddr] <= wdata;
   end

   assign rdata = rows[raddr];
endmodule

// File: rtl/stepclk_ramp_sel.sv
module stepclk_ramp_sel #(
   parameter int STEP_W    = 24,
   parameter int TBL_DEPTH = 64,
   localparam int AW       = $clog2(TBL_DEPTH),
   localparam int UW       = $clog2(TBL_DEPTH + 1)
) (
   input  logic [STEP_W-1:0] rem,
   input  logic [UW-1:0]     used,
   output logic [AW-1:0]     idx,
   output logic [UW-1:0]     used_next
);
   localparam logic [UW-1:0] FULL = UW'(TBL_DEPTH);

   logic slowing;
   logic climbing;

   assign slowing  = (rem <= STEP_W'(used));
   assign climbing = !slowing && (used != FULL);

   always_comb begin
      if (slowing)       idx = AW'(rem - 1'b1);
      else if (climbing) idx = AW'(used);
      else               idx = AW'(TBL_DEPTH - 1);
      used_next = climbing ? used + 1'b1 : used;
   end
endmodule

// File: rtl/stepclk_gen.sv
module stepclk_gen
   import stepclk_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int TBL_W     = 16,
   parameter int TBL_DEPTH = 64,
   parameter int STEP_W    = 24,
   parameter int POS_W     = 32,
   parameter int PSEL_W    = 3,
   parameter int MIN_LEAD  = 4,
   localparam int AW       = $clog2(TBL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [STEP_W-1:0] steps_i,
   input  logic              dir_i,
   input  logic [PSEL_W-1:0] presc_i,
   input  logic              tbl_we_i,
   input  logic [AW-1:0]     tbl_addr_i,
   input  logic [TBL_W-1:0]  tbl_data_i,
   output logic              step_o,
   output logic              dir_o,
   output logic [POS_W-1:0]  pos_o,
   output logic              busy_o
);
   localparam int UW = $clog2(TBL_DEPTH + 1);
   localparam int XW = ((TBL_W > CNT_W) ? TBL_W : CNT_W) + 1;
   localparam logic [XW-1:0] SEG_MAX = {{(XW-CNT_W){1'b0}}, {CNT_W{1'b1}}};

   generate
      if (MIN_LEAD < 2 || MIN_LEAD >= (1 << CNT_W))
         $error("stepclk_gen: MIN_LEAD must lie in 2 .. 2^CNT_W-1");
      if ((1 << AW) != TBL_DEPTH || TBL_DEPTH < 2)
         $error("stepclk_gen: TBL_DEPTH must be a power of two >= 2");
      if (STEP_W <= UW || PSEL_W < 1 || CNT_W < 4 || CNT_W > 30)
         $error("stepclk_gen: width parameters out of range");
   endgenerate

   stepclk_phase_t    phase_q;
   logic [CNT_W-1:0]  cmp_q;
   logic [TBL_W-1:0]  left_q;
   logic [TBL_W-1:0]  iv_q;
   logic [STEP_W-1:0] rem_q;
   logic [UW-1:0]     used_q;
   logic [PSEL_W-1:0] psel_q;
   logic [POS_W-1:0]  pos_q;
   logic              step_q;
   logic              dir_q;

   logic              tick;
   logic [CNT_W-1:0]  cnt;
   logic [AW-1:0]     sel_idx;
   logic [UW-1:0]     used_nx;
   logic [TBL_W-1:0]  tbl_rd;
   logic [TBL_W-1:0]  fresh_iv;
   logic [TBL_W-1:0]  arm_src;
   logic              arm_big;
   logic [CNT_W-1:0]  arm_seg;
   logic [TBL_W-1:0]  arm_left;
   logic              seg_pending;
   logic              match;
   logic              idle;

   assign idle = (phase_q == PH_IDLE);

   stepclk_timebase #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .psel(psel_q), .tick_o(tick), .cnt_o(cnt)
   );

   stepclk_ramp_sel #(.STEP_W(STEP_W), .TBL_DEPTH(TBL_DEPTH)) u_sel (
      .rem(rem_q), .used(used_q), .idx(sel_idx), .used_next(used_nx)
   );

   stepclk_ramp_mem #(.TBL_W(TBL_W), .TBL_DEPTH(TBL_DEPTH)) u_mem (
      .clk(clk), .we(tbl_we_i && idle), .waddr(tbl_addr_i), .wdata(tbl_data_i),
      .raddr(sel_idx), .rdata(tbl_rd)
   );

   // zero entries stretch to one tick so a target is never already behind
   assign fresh_iv    = (tbl_rd == '0) ? TBL_W'(1) : tbl_rd;
   assign seg_pending = (left_q != '0);
   assign match       = !idle && tick && (cnt == cmp_q);

   always_comb begin
      if (seg_pending)            arm_src = left_q;
      else if (phase_q == PH_LOW) arm_src = iv_q;
      else                        arm_src = fresh_iv;
      arm_big  = (XW'(arm_src) > SEG_MAX);
      arm_seg  = arm_big ? {CNT_W{1'b1}} : CNT_W'(arm_src);
      arm_left = arm_big ? arm_src - TBL_W'(SEG_MAX) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cmp_q   <= '0;
         left_q  <= '0;
         iv_q    <= '0;
         rem_q   <= '0;
         used_q  <= '0;
         psel_q  <= '0;
         pos_q   <= '0;
         step_q  <= 1'b0;
         dir_q   <= 1'b0;
      end else if (idle) begin
         if (start_i && steps_i != '0) begin
            dir_q   <= dir_i;
            psel_q  <= presc_i;
            rem_q   <= steps_i;
            used_q  <= '0;
            left_q  <= '0;
            cmp_q   <= cnt + CNT_W'(MIN_LEAD);
            phase_q <= PH_LEAD;
         end
      end else if (match) begin
         cmp_q  <= cmp_q + arm_seg;
         left_q <= arm_left;
         if (!seg_pending) begin
            unique case (phase_q)
               PH_LEAD: begin
                  iv_q    <= fresh_iv;
                  used_q  <= used_nx;
                  rem_q   <= rem_q - 1'b1;
                  phase_q <= PH_LOW;
               end
               PH_LOW: begin
                  step_q  <= 1'b1;
                  pos_q   <= dir_q ? pos_q + 1'b1 : pos_q - 1'b1;
                  phase_q <= PH_HIGH;
               end
               PH_HIGH: begin
                  step_q <= 1'b0;
                  if (rem_q == '0) begin
                     phase_q <= PH_IDLE;
                  end else begin
                     iv_q    <= fresh_iv;
                     used_q  <= used_nx;
                     rem_q   <= rem_q - 1'b1;
                     phase_q <= PH_LOW;
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign step_o = step_q;
   assign dir_o  = dir_q;
   assign pos_o  = pos_q;
   assign busy_o = !idle;
endmodule

// File: rtl/stepclk_gen_chk.sv
module stepclk_gen_chk #(
   parameter int POS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_o,
   input logic             dir_o,
   input logic [POS_W-1:0] pos_o,
   input logic             busy_o
);
   a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !step_o);

   a_r8_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $fell(step_o));

   a_r3_step_within_move: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(step_o) |-> (busy_o || $past(busy_o)));

   a_r7_pos_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pos_o) |-> $rose(step_o));

   a_r7_pos_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_o) |-> ((pos_o - $past(pos_o)) == (dir_o ? POS_W'(1) : {POS_W{1'b1}})));

   a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(dir_o));
endmodule

bind stepclk_gen stepclk_gen_chk #(.POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .step_o(step_o), .dir_o(dir_o),
   .pos_o(pos_o), .busy_o(busy_o)
);

// File: tb/tb_stepclk_gen.sv
`timescale 1ns/1ps
module tb_stepclk_gen;
   localparam int CNT_W = 8;
   localparam int DEPTH = 4;
   localparam int LEAD  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] steps_i = '0;
   logic        dir_i = 1'b0;
   logic [2:0]  presc_i = '0;
   logic        tbl_we_i = 1'b0;
   logic [1:0]  tbl_addr_i = '0;
   logic [15:0] tbl_data_i = '0;
   logic        step_o, dir_o, busy_o;
   logic [15:0] pos_o;

   int checks = 0;
   int errors = 0;
   int tbl [DEPTH];

   always #2.5 clk = ~clk;

   stepclk_gen #(.CNT_W(CNT_W), .TBL_W(16), .TBL_DEPTH(DEPTH), .STEP_W(16),
                 .POS_W(16), .PSEL_W(3), .MIN_LEAD(LEAD)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .steps_i(steps_i),
      .dir_i(dir_i), .presc_i(presc_i), .tbl_we_i(tbl_we_i),
      .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i), .step_o(step_o),
      .dir_o(dir_o), .pos_o(pos_o), .busy_o(busy_o)
   );

   // {steps, dir, prescaler, expected position change}
   localparam logic [35:0] VECS [5] = '{
      {16'd5,  1'b1, 3'd0, 16'sd5},
      {16'd10, 1'b0, 3'd1, -16'sd10},
      {16'd1,  1'b1, 3'd2, 16'sd1},
      {16'd4,  1'b1, 3'd0, 16'sd4},
      {16'd6,  1'b0, 3'd0, -16'sd6}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ent(input int k, input int n);
      int i = k - 1;
      if (n - k < i) i = n - k;
      if (DEPTH - 1 < i) i = DEPTH - 1;
      return (tbl[i] == 0) ? 1 : tbl[i];
   endfunction

   task automatic wr_tbl(input int a, input int v);
      @(negedge clk);
      tbl_we_i = 1'b1; tbl_addr_i = 2'(a); tbl_data_i = 16'(v);
      @(negedge clk);
      tbl_we_i = 1'b0;
      tbl[a] = v;
   endtask

   // poke: 0 none, 1 start during move, 2 table write during move
   task automatic run_move(input int n, input bit d, input int ps, input int exp_delta,
                           input int poke, input string treq);
      int pos0, rises, edges, last_t, t, k, want, bad_act, bad_exp;
      bit prev, dir_bad, bad, poked;
      @(negedge clk);
      pos0 = int'($signed(pos_o));
      start_i = 1'b1; steps_i = 16'(n); dir_i = d; presc_i = 3'(ps);
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
      chk(dir_o == d && step_o == 1'b0, "R6", "dir set before first edge", int'(dir_o), int'(d));
      t = 1; last_t = 1; prev = step_o; edges = 0; rises = 0;
      dir_bad = 0; bad = 0; poked = 0; bad_act = 0; bad_exp = 0;
      while (busy_o && t < 60000) begin
         @(negedge clk);
         start_i = 1'b0; tbl_we_i = 1'b0;
         t++;
         if (!poked && edges == 2 && poke == 1) begin
            poked = 1; start_i = 1'b1; steps_i = 16'd7; dir_i = ~d; presc_i = 3'd5;
         end
         if (!poked && edges == 2 && poke == 2) begin
            poked = 1; tbl_we_i = 1'b1; tbl_addr_i = 2'd0; tbl_data_i = 16'd5;
         end
         if (step_o != prev) begin
            edges++;
            k = (edges + 1) / 2;
            want = ent(k, n) << ps;
            if (edges % 2 == 1) begin
               rises++;
               if (k == 1) begin
                  if (t - last_t <= want && !bad) begin bad = 1; bad_act = t - last_t; bad_exp = want + 1; end
               end else if (t - last_t != want && !bad) begin
                  bad = 1; bad_act = t - last_t; bad_exp = want;
               end
            end else if (t - last_t != want && !bad) begin
               bad = 1; bad_act = t - last_t; bad_exp = want;
            end
            if (dir_o != d) dir_bad = 1;
            last_t = t; prev = step_o;
         end
      end
      start_i = 1'b0; tbl_we_i = 1'b0;
      chk(!bad, treq, "half-period length", bad_act, bad_exp);
      chk(rises == n, "R3", "rising edges in move", rises, n);
      chk(int'($signed(pos_o)) - pos0 == exp_delta, "R7", "position change",
          int'($signed(pos_o)) - pos0, exp_delta);
      chk(!busy_o && !step_o, "R8", "idle and low after last step", int'(step_o), 0);
      chk(!dir_bad, "R6", "direction held during move", int'(dir_bad), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(step_o == 0 && busy_o == 0, "R1", "step/busy at reset", int'(step_o) + int'(busy_o), 0);
      chk(dir_o == 0 && pos_o == 0, "R1", "dir/pos at reset", int'(pos_o), 0);
      rst_n = 1'b1;
      // R10: load ramp 40,30,20,10 while idle
      wr_tbl(0, 40); wr_tbl(1, 30); wr_tbl(2, 20); wr_tbl(3, 10);

      // R4 and R2: profile walk over the vector table
      for (int i = 0; i < 5; i++) begin
         run_move(int'(VECS[i][35:20]), VECS[i][19], int'(VECS[i][18:16]),
                  int'($signed(VECS[i][15:0])), 0, "R4");
      end

      // R9: start with zero steps is ignored
      @(negedge clk);
      start_i = 1'b1; steps_i = '0; dir_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 0 && step_o == 0, "R9", "zero-step start ignored", int'(busy_o), 0);

      // R9: start during a move is ignored (count, dir, prescaler)
      run_move(3, 1'b1, 0, 3, 1, "R9");
      // R10: table write during a move ignored; next move still uses 40
      run_move(2, 1'b0, 0, -2, 2, "R10");
      run_move(1, 1'b1, 0, 1, 0, "R10");

      // R5: interval beyond counter range split silently
      wr_tbl(0, 600);
      run_move(1, 1'b1, 0, 1, 0, "R5");
      run_move(2, 1'b0, 1, -2, 0, "R5");

      // R10: zero entry acts as one tick
      wr_tbl(0, 0);
      run_move(1, 1'b1, 0, 1, 0, "R10");
      wr_tbl(0, 40);

      // R2: largest prescaler setting
      run_move(1, 1'b0, 7, -1, 0, "R2");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule